// File: doc/BRIEF.md
# Circular Pass-Window Finder

This block takes a calibration result vector with one bit per delay tap (bit value 0 = the tap passed, 1 = it failed) and two reference taps: a low marker and a high marker. It finds the contiguous run of passing taps that holds the high marker, or that lies just to the left of it when the marker itself fails. The tap range is treated as a ring, so a window may run past the last tap and is then reported with a right end above the range end (up to twice the range minus one). The block reports the window's left and right taps, the signed distance from the high marker to the right end, the signed distance from the left end to the low marker, and an error flag.

Software or a training sequencer loads the vector and markers, pulses `start`, and waits for the one-cycle `done` pulse. The search walks one tap per clock. It first tallies the passing taps over the whole vector. It then probes the tap at the high marker, scans to find the right end, and finally scans leftward to find the left end. Producing the vector is outside this block.

Top module: `pwin_finder`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0, and `left_ep`, `right_ep`, `hi_diff` and `lo_diff` are 0.
- R2: A start is rejected with `done`=1 and `err`=1 on the next cycle if the low marker exceeds TAPS-1, or the high marker is below the low marker, or the high marker exceeds 2*TAPS-1.
- R3: A vector with every bit 1 (all taps fail) ends with `err`=1.
- R4: A vector with every bit 0 (all taps pass) ends with `err`=1, `left_ep`=0 and `right_ep`=TAPS-1.
- R5: When the tap at the high marker (index hi mod TAPS) passes, the block scans rightward from the marker for the first failing tap, up to 2*TAPS-1 if the marker exceeds TAPS-1 and up to marker+TAPS-1 otherwise. The right end is that tap minus one. No fail within the limit sets `err`.
- R6: When the tap at the high marker fails, the block scans leftward from the marker for the first passing tap, down to marker-TAPS+1 if the marker exceeds TAPS-1 and down to 0 otherwise. That tap is the right end. No pass within the limit sets `err`.
- R7: From the right end the block scans leftward over passing taps for a failing tap, down to right-TAPS+1 if the right end exceeds TAPS-1 and down to 0 otherwise. The left end is that tap plus one. No fail within the limit sets `err`.
- R8: On success `hi_diff` = right_ep - high marker and `lo_diff` = low marker - left_ep, both two's-complement signed.
- R9: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after an accepted start until `done`. A start while busy is ignored.
- R10: Tap indices are taken modulo TAPS, so a window that wraps past tap TAPS-1 is reported with `right_ep` above TAPS-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (sampled when idle) |
| fail_vec | input | TAPS | Per-tap result, 1 = fail |
| lo_mark | input | EP_W+1 | Low marker tap |
| hi_mark | input | EP_W+1 | High marker tap (may exceed TAPS-1) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Search failed (valid with done) |
| left_ep | output | EP_W | Window left end |
| right_ep | output | EP_W | Window right end (may exceed TAPS-1) |
| hi_diff | output | EP_W+1 | Signed right_ep - high marker |
| lo_diff | output | EP_W+1 | Signed low marker - left_ep |

## Verification
A single run of passing taps is swept over start positions and widths, including runs that wrap past the last tap. High markers are placed inside the run, just past its right edge, and at the marker plus the range size. These placements separate the rightward and leftward right-end searches and show whether wrapped right ends are kept unreduced. Mixed vectors built from a fixed pseudo-random source, with several runs, check that the run found is the one tied to the marker. The all-pass vector, the all-fail vector and each kind of illegal marker show the error paths, and a start pulse sent during a run shows that such a start is ignored.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_COUNT  = 3'd1,
        S_PROBE  = 3'd2,
        S_RFWD   = 3'd3,
        S_RBACK  = 3'd4,
        S_LSCAN  = 3'd5,
        S_FIN    = 3'd6
    } pwin_state_e;
endpackage

// File: rtl/pwin_tap_select.sv
module pwin_tap_select #(
    parameter int TAPS  = 64,
    parameter int IDX_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]  vec,
    input  logic [IDX_W-1:0] idx,
    output logic             failed
);
    assign failed = vec[idx];
endmodule

// File: rtl/pwin_pass_tally.sv
module pwin_pass_tally #(
    parameter int TAPS = 64,
    parameter int CW   = $clog2(TAPS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic          failed,
    output logic [CW-1:0] passes
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (en && !failed)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign passes = cnt_q;

    // R3
    tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TAPS));
endmodule

// File: rtl/pwin_marker_guard.sv
module pwin_marker_guard #(
    parameter int TAPS = 64,
    parameter int MK_W = $clog2(TAPS) + 2
) (
    input  logic [MK_W-1:0] lo_mark,
    input  logic [MK_W-1:0] hi_mark,
    output logic            bad
);
    localparam logic [MK_W-1:0] LAST_T = MK_W'(TAPS - 1);
    localparam logic [MK_W-1:0] WRAP_T = MK_W'(2 * TAPS - 1);

    assign bad = (lo_mark > LAST_T) || (hi_mark < lo_mark) || (hi_mark > WRAP_T);
endmodule

// File: rtl/pwin_finder.sv
module pwin_finder
    import pwin_pkg::*;
#(
    parameter int TAPS  = 64,
    parameter int IDX_W = $clog2(TAPS),
    parameter int EP_W  = IDX_W + 1,
    parameter int MK_W  = EP_W + 1,
    parameter int DF_W  = EP_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [TAPS-1:0]        fail_vec,
    input  logic [MK_W-1:0]        lo_mark,
    input  logic [MK_W-1:0]        hi_mark,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [EP_W-1:0]        left_ep,
    output logic [EP_W-1:0]        right_ep,
    output logic signed [DF_W-1:0] hi_diff,
    output logic signed [DF_W-1:0] lo_diff
);
    localparam logic [EP_W-1:0] END_T  = EP_W'(TAPS - 1);
    localparam logic [EP_W-1:0] WRAP_T = EP_W'(2 * TAPS - 1);
    localparam logic [EP_W-1:0] FULL_T = EP_W'(TAPS);

    typedef struct packed {
        pwin_state_e     state;
        logic [TAPS-1:0] vec;
        logic [EP_W-1:0] lo;
        logic [EP_W-1:0] hi;
        logic [EP_W-1:0] cur;
        logic [EP_W-1:0] lmt;
        logic [EP_W-1:0] left;
        logic [EP_W-1:0] right;
        logic [DF_W-1:0] hd;
        logic [DF_W-1:0] ld;
        logic            done;
        logic            err;
    } fsm_t;

    fsm_t q, d;

    logic             bad;
    logic             tap_fail;
    logic [IDX_W-1:0] sel;
    logic [EP_W-1:0]  passes;
    logic             tally_clr;
    logic             tally_en;

    pwin_marker_guard #(.TAPS(TAPS), .MK_W(MK_W)) guard_i (
        .lo_mark (lo_mark),
        .hi_mark (hi_mark),
        .bad     (bad)
    );

    assign sel = (q.state == S_PROBE) ? q.hi[IDX_W-1:0] : q.cur[IDX_W-1:0];

    pwin_tap_select #(.TAPS(TAPS), .IDX_W(IDX_W)) tsel_i (
        .vec    (q.vec),
        .idx    (sel),
        .failed (tap_fail)
    );

    assign tally_clr = (q.state == S_IDLE) && start;
    assign tally_en  = (q.state == S_COUNT);

    pwin_pass_tally #(.TAPS(TAPS), .CW(EP_W)) tally_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tally_clr),
        .en     (tally_en),
        .failed (tap_fail),
        .passes (passes)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (start) begin
                    d.vec   = fail_vec;
                    d.lo    = lo_mark[EP_W-1:0];
                    d.hi    = hi_mark[EP_W-1:0];
                    d.err   = 1'b0;
                    d.left  = '0;
                    d.right = '0;
                    d.hd    = '0;
                    d.ld    = '0;
                    d.cur   = '0;
                    if (bad) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.state = S_COUNT;
                    end
                end
            end
            S_COUNT: begin
                if (q.cur[IDX_W-1:0] == IDX_W'(TAPS - 1))
                    d.state = S_PROBE;
                else
                    d.cur = q.cur + 1'b1;
            end
            S_PROBE: begin
                d.cur = q.hi;
                if (passes == '0) begin
                    d.err   = 1'b1;
                    d.state = S_FIN;
                end else if (passes == FULL_T) begin
                    d.left  = '0;
                    d.right = END_T;
                    d.err   = 1'b1;
                    d.state = S_FIN;
                end else if (!tap_fail) begin
                    d.lmt   = (q.hi > END_T) ? WRAP_T : q.hi + END_T;
                    d.state = S_RFWD;
                end else begin
                    d.lmt   = (q.hi > END_T) ? q.hi - END_T : '0;
                    d.state = S_RBACK;
                end
            end
            S_RFWD: begin
                if (tap_fail) begin
                    d.right = q.cur - 1'b1;
                    d.cur   = q.cur - 1'b1;
                    d.lmt   = (q.cur - 1'b1 > END_T) ? q.cur - 1'b1 - END_T : '0;
                    d.state = S_LSCAN;
                end else if (q.cur == q.lmt) begin
                    d.err   = 1'b1;
                    d.state = S_FIN;
                end else begin
                    d.cur = q.cur + 1'b1;
                end
            end
            S_RBACK: begin
                if (!tap_fail) begin
                    d.right = q.cur;
                    d.lmt   = (q.cur > END_T) ? q.cur - END_T : '0;
                    d.state = S_LSCAN;
                end else if (q.cur == q.lmt) begin
                    d.err   = 1'b1;
                    d.state = S_FIN;
                end else begin
                    d.cur = q.cur - 1'b1;
                end
            end
            S_LSCAN: begin
                if (tap_fail) begin
                    d.left  = q.cur + 1'b1;
                    d.state = S_FIN;
                end else if (q.cur == q.lmt) begin
                    d.err   = 1'b1;
                    d.state = S_FIN;
                end else begin
                    d.cur = q.cur - 1'b1;
                end
            end
            S_FIN: begin
                d.done  = 1'b1;
                d.state = S_IDLE;
                if (!q.err) begin
                    d.hd = {1'b0, q.right} - {1'b0, q.hi};
                    d.ld = {1'b0, q.lo} - {1'b0, q.left};
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.state != S_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign left_ep  = q.left;
    assign right_ep = q.right;
    assign hi_diff  = q.hd;
    assign lo_diff  = q.ld;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !bad) |=> busy);

    // R2
    bad_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bad) |=> (done && err));

    // R7
    span_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (right_ep >= left_ep));

    // R10
    span_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((right_ep - left_ep) <= EP_W'(TAPS - 2)));
endmodule

// File: tb/pwin_finder_tb.sv
module pwin_finder_tb_top;
    localparam int TAPS = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [TAPS-1:0]   fv = '0;
    logic [7:0]        lo_m = '0;
    logic [7:0]        hi_m = '0;
    logic              busy, done, err;
    logic [6:0]        left_ep, right_ep;
    logic signed [7:0] hi_diff, lo_diff;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwin_finder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .fail_vec(fv),
        .lo_mark(lo_m), .hi_mark(hi_m), .busy(busy), .done(done), .err(err),
        .left_ep(left_ep), .right_ep(right_ep), .hi_diff(hi_diff), .lo_diff(lo_diff)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected result worked out from the requirements
    task automatic ref_run(input logic [TAPS-1:0] v, input int lo, input int hi,
                           output bit e, output int l, output int r);
        int pc, cur, lmt;
        e = 0; l = 0; r = 0;
        if (lo > TAPS-1 || hi < lo || hi > 2*TAPS-1) begin e = 1; return; end
        pc = 0;
        for (int k = 0; k < TAPS; k++) if (!v[k]) pc++;
        if (pc == 0) begin e = 1; return; end
        if (pc == TAPS) begin e = 1; l = 0; r = TAPS-1; return; end
        cur = hi;
        if (!v[hi % TAPS]) begin
            lmt = (hi > TAPS-1) ? 2*TAPS-1 : hi + TAPS-1;
            while (cur <= lmt && !v[cur % TAPS]) cur++;
            if (cur > lmt) begin e = 1; return; end
            r = cur - 1;
        end else begin
            lmt = (hi > TAPS-1) ? hi - TAPS + 1 : 0;
            while (cur >= lmt && v[cur % TAPS]) cur--;
            if (cur < lmt) begin e = 1; return; end
            r = cur;
        end
        cur = r;
        lmt = (r > TAPS-1) ? r - TAPS + 1 : 0;
        while (cur >= lmt && !v[cur % TAPS]) cur--;
        if (cur < lmt) begin e = 1; return; end
        l = cur + 1;
    endtask

    task automatic run(input logic [TAPS-1:0] v, input int lo, input int hi, input bit poke);
        bit e; int l, r, n; string tag;
        ref_run(v, lo, hi, e, l, r);
        if (lo > TAPS-1 || hi < lo || hi > 2*TAPS-1) tag = "R2";
        else if (&v) tag = "R3";
        else if (~|v) tag = "R4";
        else if (!v[hi % TAPS]) tag = "R5";
        else tag = "R6";
        @(negedge clk);
        fv = v; lo_m = 8'(lo); hi_m = 8'(hi); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            // R9: a start while busy must not change this run
            start = 1'b1; fv = '0; lo_m = 8'd0; hi_m = 8'd5;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        check("R9", "done seen", int'(done), 1);
        check(tag, "err", int'(err), int'(e));
        if (!e) begin
            check(tag, "right_ep", int'(right_ep), r);
            check("R7", "left_ep", int'(left_ep), l);
            check("R8", "hi_diff", int'(hi_diff), r - hi);
            check("R8", "lo_diff", int'(lo_diff), lo - l);
            if (r > TAPS-1) check("R10", "wrapped right_ep", int'(right_ep), r);
        end else if (tag == "R4") begin
            check("R4", "left_ep", int'(left_ep), 0);
            check("R4", "right_ep", int'(right_ep), TAPS-1);
        end
        @(negedge clk);
        check("R9", "done one cycle", int'(done), 0);
    endtask

    function automatic logic [TAPS-1:0] one_run(input int s, input int w);
        logic [TAPS-1:0] v = '1;
        for (int k = 0; k < w; k++) v[(s + k) % TAPS] = 1'b0;
        return v;
    endfunction

    initial begin : watchdog
        int cyc = 0;
        while (cyc < 190000) begin @(posedge clk); cyc++; end
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        int widths [4] = '{1, 5, 20, 63};
        repeat (3) @(negedge clk);
        // R1
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "err", int'(err), 0);
        check("R1", "left_ep", int'(left_ep), 0);
        check("R1", "right_ep", int'(right_ep), 0);
        check("R1", "hi_diff", int'(hi_diff), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: illegal markers
        run(one_run(10, 8), 64, 70, 0);
        run(one_run(10, 8), 20, 15, 0);
        run(one_run(10, 8), 5, 128, 0);
        run(one_run(10, 8), 0, 200, 0);
        // R3, R4
        run('1, 0, 30, 0);
        run('0, 0, 30, 0);
        run('0, 10, 100, 0);

        // Single window swept over position and width; R5, R6, R10
        for (int s = 0; s < TAPS; s += 5) begin
            for (int wi = 0; wi < 4; wi++) begin
                int w = widths[wi];
                int mid = s + w / 2;
                int past = s + w;
                int lo = (s <= mid) ? s : 0;
                run(one_run(s, w), lo, mid, 0);
                run(one_run(s, w), (s <= past) ? s : 0, past, 0);
                if (mid + TAPS <= 2*TAPS-1) run(one_run(s, w), lo, mid + TAPS, 0);
                if (past % TAPS + TAPS <= 2*TAPS-1) run(one_run(s, w), 3, past % TAPS + TAPS, 0);
            end
        end

        // Mixed vectors with several windows
        for (int i = 0; i < 60; i++) begin
            logic [TAPS-1:0] v = {$urandom(i * 7 + 1), $urandom(i * 13 + 5)};
            int hi = int'($urandom(i * 3 + 11) % 128);
            int lo = int'($urandom(i * 5 + 2) % 64);
            if (lo > hi) lo = hi % 64;
            run(v, lo, hi, 0);
        end

        // R9: start while busy ignored
        run(one_run(50, 20), 40, 60, 1);
        run(one_run(2, 9), 1, 70, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule